// File: doc/BRIEF.md
# Timecode Frame Sync Aligner

This block takes a serial stream of timecode bits that an upstream decoder has already recovered, one bit per strobe, and finds the frame boundaries in it. A frame is 80 bits long and always closes with a fixed 16-bit sync word. The block keeps the most recent 80 bits in a window. When the sync word appears at the tail of the window, it hands over the 64 payload bits in front of the sync word as one parallel word, together with a single-cycle valid pulse.

After the first match the block is locked. It stops searching and expects each later sync word exactly 80 strobes after the previous one. A lost or extra bit upstream shifts the sync word away from that position. The block then reports a one-cycle loss pulse and goes back to searching on every bit. Decoding bits from the audio waveform and interpreting the time fields inside the payload are left to other blocks.

Top module: `tc_frame_aligner`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state. After that edge `frame_valid`, `sync_lost` and `locked` are 0 and `frame_data` is all zeros.
- R2: When unlocked, a strobe whose bit completes the sync word produces a `frame_valid` pulse after that clock edge and sets `locked`. The sync word is 0,0,1,1,1,1,1,1,1,1,1,1,1,1,0,1 in order of arrival, which is 16'h3FFD with the first bit in the MSB. The pulse comes after the closing bit's edge and at no other bit of that frame.
- R3: `frame_data` carries the 64 bits received just before the sync word. The earliest of them is in bit 0 and the latest is in bit 63. `frame_data` changes only on a cycle with `frame_valid` high.
- R4: When locked, the sync check happens only on the 80th strobe after the previous sync. A sync word that ends at any other strobe produces no pulse.
- R5: When locked, if the 80th strobe does not complete the sync word, `sync_lost` pulses for one cycle, `locked` falls on the same cycle and `frame_valid` stays low.
- R6: After a loss the block searches on every strobe again. The first sync completion after the loss, including one on the very next strobe, relocks and emits its frame.
- R7: A clock edge with `bit_valid` low does not shift the window, does not advance the count and produces no pulse, whatever `bit_in` is.
- R8: `frame_valid` and `sync_lost` are each high for one cycle per event and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe: `bit_in` holds a new bit |
| bit_in | input | 1 | Decoded timecode bit |
| frame_valid | output | 1 | One-cycle pulse: a frame has been aligned |
| frame_data | output | 64 | Payload of the last aligned frame, earliest bit in bit 0 |
| locked | output | 1 | High while frames are tracked at the fixed spacing |
| sync_lost | output | 1 | One-cycle pulse: the expected sync word was missing |

## Verification
The hardest conditions to reach are the slipped-frame cases. In one, a dropped bit lets the sync word complete one strobe early, and that early match must be ignored. In the other, an extra bit pushes the sync completion one strobe past the check point, so a loss and a relock fall on consecutive strobes. The stimulus gets there by sending a locked stream of payloads, then a frame with one payload bit left out and another with one bit added in front. It also places a complete sync word inside a payload while locked. Payloads are masked so that no 11-bit run of ones can form a false sync word during search.

// File: rtl/tc_align_pkg.sv
package tc_align_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } lock_state_e;
endpackage

// File: rtl/tc_shift_window.sv
module tc_shift_window #(
  parameter int FRAME_BITS = 80,
  parameter int SYNC_BITS  = 16,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = 16'h3FFD
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic bit_in,
  output logic hit,
  output logic [FRAME_BITS-SYNC_BITS-1:0] payload
);
  localparam int PAYLOAD_BITS = FRAME_BITS - SYNC_BITS;

  logic [FRAME_BITS-1:0] win_q;
  logic [FRAME_BITS-1:0] win_d;

  // Newest bit enters at bit 0; the oldest held bit is at the top.
  assign win_d = {win_q[FRAME_BITS-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst)           win_q <= '0;
    else if (shift_en) win_q <= win_d;
  end

  function automatic logic tail_is_sync(input logic [FRAME_BITS-1:0] w);
    return w[SYNC_BITS-1:0] == SYNC_WORD;
  endfunction

  assign hit = shift_en && tail_is_sync(win_d);

  // The earliest payload bit sits at the top of the window and goes to payload[0].
  for (genvar i = 0; i < PAYLOAD_BITS; i++) begin : g_map
    assign payload[i] = win_d[FRAME_BITS-1-i];
  end
endmodule

// File: rtl/tc_bit_counter.sv
module tc_bit_counter #(
  parameter int FRAME_BITS = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic clear,
  output logic at_check
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (clear)       cnt_q <= '0;
    else if (step)        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign at_check = (cnt_q == LAST);
endmodule

// File: rtl/tc_lock_fsm.sv
module tc_lock_fsm
  import tc_align_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic hit,
  input  logic at_check,
  output logic accept,
  output logic lose,
  output logic locked
);
  lock_state_e state_q;

  always_comb begin
    accept = 1'b0;
    lose   = 1'b0;
    if (step) begin
      unique case (state_q)
        ST_SEARCH: accept = hit;
        ST_LOCKED: begin
          accept = at_check && hit;
          lose   = at_check && !hit;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         state_q <= ST_SEARCH;
    else if (accept) state_q <= ST_LOCKED;
    else if (lose)   state_q <= ST_SEARCH;
  end

  assign locked = (state_q == ST_LOCKED);
endmodule

// File: rtl/tc_frame_aligner.sv
module tc_frame_aligner #(
  parameter int FRAME_BITS = 80,
  parameter int SYNC_BITS  = 16,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = 16'h3FFD,
  localparam int PAYLOAD_BITS = FRAME_BITS - SYNC_BITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_valid,
  input  logic                    bit_in,
  output logic                    frame_valid,
  output logic [PAYLOAD_BITS-1:0] frame_data,
  output logic                    locked,
  output logic                    sync_lost
);
  logic                    sync_hit;
  logic                    at_check;
  logic                    frame_accept;
  logic                    frame_lose;
  logic [PAYLOAD_BITS-1:0] payload_now;

  tc_shift_window #(.FRAME_BITS(FRAME_BITS), .SYNC_BITS(SYNC_BITS), .SYNC_WORD(SYNC_WORD)) u_win (
    .clk(clk), .rst(rst), .shift_en(bit_valid), .bit_in(bit_in),
    .hit(sync_hit), .payload(payload_now)
  );

  tc_bit_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk(clk), .rst(rst), .step(bit_valid), .clear(frame_accept), .at_check(at_check)
  );

  tc_lock_fsm u_fsm (
    .clk(clk), .rst(rst), .step(bit_valid), .hit(sync_hit), .at_check(at_check),
    .accept(frame_accept), .lose(frame_lose), .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_valid <= 1'b0;
      sync_lost   <= 1'b0;
      frame_data  <= '0;
    end else begin
      frame_valid <= frame_accept;
      sync_lost   <= frame_lose;
      if (frame_accept) frame_data <= payload_now;
    end
  end

  p_pulse_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(frame_valid && sync_lost));

  p_frame_implies_lock_r2: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> locked);

  p_lock_rise_emits_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> frame_valid);

  p_lost_unlocks_r5: assert property (@(posedge clk) disable iff (rst)
    sync_lost |-> (!locked && $past(locked)));

  p_lock_fall_reports_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> sync_lost);

  p_data_moves_with_valid_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(frame_data) |-> frame_valid);

  p_idle_no_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_valid) |-> (!frame_valid && !sync_lost));
endmodule

// File: tb/tb_tc_frame_aligner.sv
module tb_tc_frame_aligner;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SYNC = 16'h3FFD;
  localparam logic [63:0] MASK = 64'h7777_7777_7777_7777;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic        frame_valid;
  logic [63:0] frame_data;
  logic        locked;
  logic        sync_lost;

  int checks = 0;
  int errors = 0;
  int fv_seen = 0;
  int lost_seen = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_frame_aligner dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .frame_valid(frame_valid), .frame_data(frame_data),
    .locked(locked), .sync_lost(sync_lost)
  );

  // Pulses are counted at the edge after they appear.
  always @(posedge clk) begin
    if (!rst) begin
      if (frame_valid) fv_seen++;
      if (sync_lost)   lost_seen++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); bit_valid = 1'b0; bit_in = ~bit_in;
    end
    @(negedge clk); bit_valid = 1'b1; bit_in = b;
    @(negedge clk); bit_valid = 1'b0;
  endtask

  task automatic send_payload(input logic [63:0] p, input int first, input int last, input int gap);
    for (int j = first; j <= last; j++) send_bit(p[j], gap);
  endtask

  task automatic send_sync(input int first, input int last, input int gap);
    for (int j = first; j <= last; j++) send_bit(SYNC[15-j], gap);
  endtask

  task automatic end_frame(input logic [63:0] p, input int fv0, input int lost0, input string req);
    check(frame_valid == 1'b1, req, 64'(frame_valid), 64'd1);
    check(frame_data == p, "R3", frame_data, p);
    check(locked == 1'b1, req, 64'(locked), 64'd1);
    @(negedge clk);
    check(frame_valid == 1'b0, "R8", 64'(frame_valid), 64'd0);
    check(fv_seen - fv0 == 1, req, 64'(fv_seen - fv0), 64'd1);
    check(lost_seen - lost0 == 0, "R4", 64'(lost_seen - lost0), 64'd0);
  endtask

  function automatic logic [63:0] make_payload(input int k);
    logic [63:0] v;
    v = (64'h9E37_79B9_7F4A_7C15 * 64'(k + 1)) ^ (64'hC2B2_AE3D_27D4_EB4F >> (k % 7));
    return v & MASK;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] p;
    int fv0, lost0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(frame_valid == 1'b0, "R1", 64'(frame_valid), 64'd0);
    check(sync_lost == 1'b0,   "R1", 64'(sync_lost), 64'd0);
    check(locked == 1'b0,      "R1", 64'(locked), 64'd0);
    check(frame_data == '0,    "R1", frame_data, 64'd0);

    // R7: a full sync word presented with the strobe low is ignored
    for (int j = 0; j < 16; j++) begin
      @(negedge clk); bit_valid = 1'b0; bit_in = SYNC[15-j];
    end
    repeat (2) @(negedge clk);
    check(fv_seen == 0, "R7", 64'(fv_seen), 64'd0);
    check(locked == 1'b0, "R7", 64'(locked), 64'd0);

    // R2: first alignment from search, no pulse before the closing bit
    p = make_payload(0);
    fv0 = fv_seen; lost0 = lost_seen;
    send_payload(p, 0, 63, 0);
    send_sync(0, 14, 0);
    check(fv_seen - fv0 == 0 && frame_valid == 1'b0, "R2", 64'(fv_seen - fv0), 64'd0);
    send_sync(15, 15, 0);
    end_frame(p, fv0, lost0, "R2");

    // R4/R7: locked frames at the fixed spacing, with idle gaps; frame 4 hides a sync word
    for (int k = 1; k <= 8; k++) begin
      p = make_payload(k);
      if (k == 4) for (int j = 0; j < 16; j++) p[10+j] = SYNC[15-j];
      fv0 = fv_seen; lost0 = lost_seen;
      send_payload(p, 0, 63, k % 3);
      send_sync(0, 15, k % 3);
      end_frame(p, fv0, lost0, (k == 4) ? "R4" : "R7");
    end

    // R4: a dropped payload bit makes the sync word complete early; it is ignored
    p = make_payload(20);
    fv0 = fv_seen;
    send_payload(p, 1, 63, 0);
    send_sync(0, 15, 0);
    @(negedge clk);
    check(fv_seen - fv0 == 0, "R4", 64'(fv_seen - fv0), 64'd0);
    check(locked == 1'b1, "R4", 64'(locked), 64'd1);

    // R5: the next strobe is the check point and the sync word is missing
    p = make_payload(21);
    send_bit(p[0], 0);
    check(sync_lost == 1'b1, "R5", 64'(sync_lost), 64'd1);
    check(locked == 1'b0, "R5", 64'(locked), 64'd0);
    check(frame_valid == 1'b0, "R5", 64'(frame_valid), 64'd0);
    send_bit(p[1], 0);
    check(sync_lost == 1'b0, "R8", 64'(sync_lost), 64'd0);

    // R6: search resumes and relocks on this frame's sync word
    fv0 = fv_seen; lost0 = lost_seen;
    send_payload(p, 2, 63, 0);
    send_sync(0, 15, 0);
    end_frame(p, fv0, lost0, "R6");

    // R5/R6: an extra leading bit puts the check one strobe early, then relock on the next
    p = make_payload(30);
    send_bit(1'b0, 0);
    send_payload(p, 0, 63, 0);
    send_sync(0, 14, 0);
    check(sync_lost == 1'b1, "R5", 64'(sync_lost), 64'd1);
    check(locked == 1'b0, "R5", 64'(locked), 64'd0);
    fv0 = fv_seen; lost0 = lost_seen;
    send_sync(15, 15, 0);
    check(sync_lost == 1'b0, "R8", 64'(sync_lost), 64'd0);
    end_frame(p, fv0, lost0 + 1, "R6");

    // R4: tracking continues normally after relock
    p = make_payload(31);
    fv0 = fv_seen; lost0 = lost_seen;
    send_payload(p, 0, 63, 1);
    send_sync(0, 15, 1);
    end_frame(p, fv0, lost0, "R4");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule